// File: doc/BRIEF.md
# Compare and Test Flag Generator

This unit produces the status flags of a small 8-bit controller for four flag-only operations: compare two operands, compare two operands while also subtracting the incoming carry, compare an operand against an immediate constant, and test one operand for zero or negative. The subtraction result is used only to form the flags and is then dropped. No general-purpose register is ever written.

The caller supplies the present 8-bit flag byte. The unit returns the updated byte combinationally. Only bits 5 to 0 change; the two top bits are copied through. A small flag register captures the updated byte on a clock edge when its write enable is high and holds its value otherwise. Instruction decode, the register file and all other arithmetic operations stay outside this block.

Top module: `cmpflag_unit`

## Requirements
- R1: Flag byte bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1 and C=0. For compare (op_sel=0), the unit forms opa minus opb. C=1 when that unsigned subtraction borrows, N=result bit 7, and Z=1 when the 8-bit result is zero.
- R2: For compare-immediate (op_sel=2), imm takes the place of opb. opb then has no effect on the flags.
- R3: For compare-with-carry (op_sel=1), the incoming C (flags_in bit 0) is also subtracted. Z is 1 only when the result is zero and the incoming Z (bit 1) was already 1, so this operation can keep Z set but can never newly set it.
- R4: For test (op_sel=3), the result is opa AND opa. Z=1 when opa is zero, N=opa bit 7, V=0, and C and H keep their incoming values.
- R5: After every operation, S equals N XOR V.
- R6: For the subtracting operations, H=1 when the low nibble borrows from the high nibble (low nibble of the minuend less than the low nibble of the subtrahend plus the carry in).
- R7: For the subtracting operations, V=1 when the two operands have different signs and the sign of the result differs from the sign of opa.
- R8: Bits 7 and 6 of flags_next always equal bits 7 and 6 of flags_in, and the flag register stores them unchanged.
- R9: On a rising clock edge with flags_we=1, flags_q takes the value of flags_next. With flags_we=0, flags_q keeps its value.
- R10: While rst_n is low, flags_q is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_sel | input | 2 | 0 compare, 1 compare with carry, 2 compare immediate, 3 test |
| opa | input | 8 | Destination operand (minuend, or the operand under test) |
| opb | input | 8 | Source operand (subtrahend for compare and compare with carry) |
| imm | input | 8 | Immediate constant used by compare-immediate |
| flags_in | input | 8 | Present flag byte |
| flags_we | input | 1 | Load enable of the flag register |
| flags_next | output | 8 | Updated flag byte (combinational) |
| flags_q | output | 8 | Registered flag byte |

## Verification
The bench builds the unit with DATA_W=8 and NIB_W=4. These are the only values where the top bit is the sign and the half-carry sits at bit 3, so every sign-overflow edge (0x80, 0x7F) and every nibble-borrow edge (0x10 minus 0x01) can be reached directly. Directed cases cover the borrow chain of a multi-byte compare, in which Z may only survive. A sweep over operand pairs and incoming flag bytes then compares both the combinational and the registered flags with a model built on integer arithmetic.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  typedef enum logic [1:0] {
    OP_CMP = 2'd0,
    OP_CPC = 2'd1,
    OP_CPI = 2'd2,
    OP_TST = 2'd3
  } cmpf_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;
  localparam int FLG_W = 8;
endpackage

// File: rtl/cmpf_sub.sv
module cmpf_sub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              zin,
  input  logic              chain_z,
  output logic              h,
  output logic              v,
  output logic              n,
  output logic              z,
  output logic              c
);
  localparam int FW = DATA_W + 1;
  localparam int LW = NIB_W + 1;

  logic [FW-1:0]     full;
  logic [LW-1:0]     low;
  logic [DATA_W-1:0] res;
  logic              is_zero;

  always_comb begin
    full    = {1'b0, a} - {1'b0, b} - FW'(cin);
    low     = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - LW'(cin);
    res     = full[DATA_W-1:0];
    is_zero = (res == '0);
    c       = full[DATA_W];
    h       = low[NIB_W];
    n       = res[DATA_W-1];
    v       = (a[DATA_W-1] ^ b[DATA_W-1]) & (res[DATA_W-1] ^ a[DATA_W-1]);
    z       = chain_z ? (is_zero & zin) : is_zero;
  end
endmodule

// File: rtl/cmpf_tst.sv
module cmpf_tst #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  output logic              n,
  output logic              z
);
  logic [DATA_W-1:0] res;

  always_comb begin
    res = a & a;
    n   = res[DATA_W-1];
    z   = (res == '0);
  end
endmodule

// File: rtl/cmpf_reg.sv
module cmpf_reg
  import cmpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FLG_W-1:0] d,
  output logic [FLG_W-1:0] q
);
  logic [FLG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_LOAD_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d))); // R9
  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R9
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm,
  input  logic [FLG_W-1:0]  flags_in,
  input  logic              flags_we,
  output logic [FLG_W-1:0]  flags_next,
  output logic [FLG_W-1:0]  flags_q
);
  cmpf_op_e          op;
  logic [DATA_W-1:0] subtrahend;
  logic              carry_in;
  logic              is_chain;
  logic              s_h, s_v, s_n, s_z, s_c;
  logic              t_n, t_z;
  logic              f_h, f_v, f_n, f_z, f_c;

  always_comb begin
    op         = cmpf_op_e'(op_sel);
    subtrahend = (op == OP_CPI) ? imm : opb;
    is_chain   = (op == OP_CPC);
    carry_in   = is_chain & flags_in[FLG_C];
  end

  cmpf_sub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_sub (
    .a       (opa),
    .b       (subtrahend),
    .cin     (carry_in),
    .zin     (flags_in[FLG_Z]),
    .chain_z (is_chain),
    .h       (s_h),
    .v       (s_v),
    .n       (s_n),
    .z       (s_z),
    .c       (s_c)
  );

  cmpf_tst #(.DATA_W(DATA_W)) u_tst (
    .a (opa),
    .n (t_n),
    .z (t_z)
  );

  always_comb begin
    if (op == OP_TST) begin
      f_h = flags_in[FLG_H];
      f_c = flags_in[FLG_C];
      f_v = 1'b0;
      f_n = t_n;
      f_z = t_z;
    end else begin
      f_h = s_h;
      f_c = s_c;
      f_v = s_v;
      f_n = s_n;
      f_z = s_z;
    end
    flags_next        = flags_in;
    flags_next[FLG_H] = f_h;
    flags_next[FLG_S] = f_n ^ f_v;
    flags_next[FLG_V] = f_v;
    flags_next[FLG_N] = f_n;
    flags_next[FLG_Z] = f_z;
    flags_next[FLG_C] = f_c;
  end

  cmpf_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flags_we),
    .d     (flags_next),
    .q     (flags_q)
  );

  AST_CHAIN_Z_ONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'd1 && !flags_in[1]) |-> !flags_next[1]); // R3
  AST_TEST_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'd3) |-> (!flags_next[3] && flags_next[0] == flags_in[0]
                          && flags_next[5] == flags_in[5])); // R4
  AST_STORED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> (flags_q[4] == (flags_q[2] ^ flags_q[3]))); // R5
  AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> (flags_q[7:6] == $past(flags_in[7:6]))); // R8
  AST_EQUAL_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'd0 && opa == opb) |-> (flags_next[1] && !flags_next[0])); // R1
endmodule

// File: tb/cmpflag_unit_tb.sv
module cmpflag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic       clk;
  logic       rst_n;
  logic [1:0] op_sel;
  logic [7:0] opa, opb, imm, flags_in;
  logic       flags_we;
  logic [7:0] flags_next, flags_q;

  int n_chk;
  int n_bad;
  bit done;

  logic [7:0] exp_q_model;
  logic [7:0] exp_queue[$];
  string      tag_queue[$];

  cmpflag_unit #(.DATA_W(8), .NIB_W(4)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .opa        (opa),
    .opb        (opb),
    .imm        (imm),
    .flags_in   (flags_in),
    .flags_we   (flags_we),
    .flags_next (flags_next),
    .flags_q    (flags_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model(input logic [1:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic [7:0] k,
                                       input logic [7:0] fin);
    logic [7:0] r;
    logic h, s, v, n, z, c;
    int cin, rr, d, sa, sr, sd, lo;
    r = fin;
    if (op == 2'd3) begin
      z = (a == 8'h00);
      n = a[7];
      v = 1'b0;
      c = fin[0];
      h = fin[5];
    end else begin
      cin = (op == 2'd1) ? int'(fin[0]) : 0;
      rr  = (op == 2'd2) ? int'(k) : int'(b);
      d   = int'(a) - rr - cin;
      lo  = int'(a[3:0]) - (rr % 16) - cin;
      sa  = a[7] ? int'(a) - 256 : int'(a);
      sr  = (rr >= 128) ? rr - 256 : rr;
      sd  = sa - sr - cin;
      c   = (d < 0);
      h   = (lo < 0);
      v   = (sd > 127) || (sd < -128);
      d   = (d + 256) % 256;
      n   = (d >= 128);
      z   = (d == 0) && ((op == 2'd1) ? fin[1] : 1'b1);
    end
    s = n ^ v;
    r[5:0] = {h, s, v, n, z, c};
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] k,
                       input logic [7:0] fin, input logic we);
    logic [7:0] e;
    @(negedge clk);
    op_sel   = op;
    opa      = a;
    opb      = b;
    imm      = k;
    flags_in = fin;
    flags_we = we;
    #1;
    e = model(op, a, b, k, fin);
    check(tag, flags_next, e);
    if (we) exp_q_model = e;
    exp_queue.push_back(exp_q_model);
    tag_queue.push_back({tag, " stored"});
  endtask

  initial begin : monitor
    logic [7:0] e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_queue.size() > 0) begin
        e = exp_queue.pop_front();
        t = tag_queue.pop_front();
        check(t, flags_q, e);
      end
    end
  end

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    n_chk = 0; n_bad = 0; done = 0;
    exp_q_model = 8'h00;
    rst_n = 1'b0;
    op_sel = 2'd0; opa = 8'h00; opb = 8'h00; imm = 8'h00;
    flags_in = 8'h00; flags_we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset value", flags_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    drive("R1 cmp 05-03",          2'd0, 8'h05, 8'h03, 8'h00, 8'h00, 1'b1);
    drive("R1 cmp 03-05 borrow",   2'd0, 8'h03, 8'h05, 8'h00, 8'h00, 1'b1);
    drive("R1 cmp equal",          2'd0, 8'h5A, 8'h5A, 8'h00, 8'h3F, 1'b1);
    drive("R7 cmp 80-01 overflow", 2'd0, 8'h80, 8'h01, 8'h00, 8'h00, 1'b1);
    drive("R7 cmp 7F-FF overflow", 2'd0, 8'h7F, 8'hFF, 8'h00, 8'h00, 1'b1);
    drive("R6 cmp 10-01 half",     2'd0, 8'h10, 8'h01, 8'h00, 8'h00, 1'b1);
    drive("R2 cpi uses imm",       2'd2, 8'h40, 8'h40, 8'h41, 8'h00, 1'b1);
    drive("R2 cpi equal imm",      2'd2, 8'h33, 8'h99, 8'h33, 8'h00, 1'b1);
    drive("R3 cpc z kept",         2'd1, 8'h12, 8'h12, 8'h00, 8'h02, 1'b1);
    drive("R3 cpc z not set",      2'd1, 8'h12, 8'h12, 8'h00, 8'h00, 1'b1);
    drive("R3 cpc carry borrow",   2'd1, 8'h12, 8'h12, 8'h00, 8'h03, 1'b1);
    drive("R3 cpc carry zero",     2'd1, 8'h13, 8'h12, 8'h00, 8'h03, 1'b1);
    drive("R4 tst zero keeps C H", 2'd3, 8'h00, 8'hFF, 8'h00, 8'h29, 1'b1);
    drive("R4 tst negative",       2'd3, 8'h80, 8'h00, 8'h00, 8'h08, 1'b1);
    drive("R5 sign from N and V",  2'd0, 8'h80, 8'h7F, 8'h00, 8'h00, 1'b1);
    drive("R8 top bits pass",      2'd0, 8'h01, 8'h02, 8'h00, 8'hC0, 1'b1);
    drive("R8 top bits tst",       2'd3, 8'h7F, 8'h00, 8'h00, 8'h40, 1'b1);
    drive("R9 hold no we",         2'd0, 8'h00, 8'h01, 8'h00, 8'h80, 1'b0);
    drive("R9 hold no we 2",       2'd3, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0);
    drive("R9 load again",         2'd2, 8'h20, 8'h00, 8'h20, 8'h80, 1'b1);

    for (int i = 0; i < 64; i++) begin
      drive("R1 sweep", 2'(i % 4), 8'((i * 37) % 256), 8'((i * 91 + 13) % 256),
            8'((i * 53 + 7) % 256), 8'((i * 29) % 256), 1'(i % 5 != 0));
    end

    @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule